// File: doc/BRIEF.md
# Test-Port Memory Access Engine

This block is a user data register chain that sits behind a boundary-scan test access port. It lets a host read, program or probe an external parallel ROM or a RAM using nothing but the serial test pins. The TAP controller itself is outside the block. It hands the block a selected-register flag and single-cycle capture, shift and update pulses, all synchronous to the system clock. It also hands over a two-bit command word.

The four commands are as follows:

| Code | Operation |
|---|---|
| 2'b00 | Load the address counter |
| 2'b01 | Step the address counter |
| 2'b10 | Read a byte and shift it out |
| 2'b11 | Shift a byte in and write it |

When test mode is off, the block passes the CPU's read and write strobes and chip selects straight through to the memory pins. It then drives neither the address nor the data bus. When test mode is on, the block holds the CPU in reset and takes over the address bus, the data bus, both chip selects and both strobes. Every strobe and select stays inactive except during an access that the engine itself times.

Top module: `jte_mem_engine`

## Requirements
- R1: After reset the address counter is 0. In test mode with no access running, the read strobe, write strobe and both chip selects are high and the data bus is not driven.
- R2: With command 2'b00, each shift pulse moves the 20-bit address chain one place toward bit 0. The TDI bit enters at bit 19, so a value shifted in least significant bit first ends up aligned. An update copies the chain into the address counter. A capture loads the counter into the chain. TDO always shows chain bit 0.
- R3: With command 2'b01, an update adds one to the address counter, and 20'hFFFFF steps to 0. TDO reads 0.
- R4: With command 2'b10, a capture starts a read. The read strobe and the chosen chip select stay low for exactly RD_CYCLES clocks (default 3) while the address holds still. The byte on the bus in the last of those clocks is latched, and shift pulses then move it out on TDO least significant bit first.
- R5: With command 2'b11, eight shift pulses load a data byte least significant bit first. An update then drives that byte on the data bus with the write strobe low for exactly WR_CYCLES clocks (default 4). The data bus is driven only while the write strobe is low.
- R6: The device-select input chooses the chip select for an access: 0 picks the ROM and 1 picks the RAM. At most one chip select is ever low in test mode.
- R7: In test mode the CPU reset output is low and the address bus output enable is high.
- R8: In normal mode the memory strobes and chip selects follow the CPU inputs and the CPU reset output is high. Neither bus is driven, and capture, shift and update pulses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_mode | input | 1 | 1: the engine owns the memory pins; 0: the CPU owns them |
| dr_sel | input | 1 | This data register is selected by the TAP |
| cmd | input | 2 | Command word (00 load address, 01 step, 10 read, 11 write) |
| cap_dr | input | 1 | Capture pulse, one clock |
| shift_dr | input | 1 | Shift pulse, one clock per bit |
| upd_dr | input | 1 | Update pulse, one clock |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |
| dev_sel | input | 1 | Target device: 0 ROM, 1 RAM |
| cpu_rd_n | input | 1 | CPU read strobe |
| cpu_wr_n | input | 1 | CPU write strobe |
| cpu_rom_cs_n | input | 1 | CPU ROM select |
| cpu_ram_cs_n | input | 1 | CPU RAM select |
| cpu_rst_n | output | 1 | Reset to the CPU, low in test mode |
| mem_addr | output | 20 | Address to memory |
| mem_addr_oe | output | 1 | Address bus output enable |
| mem_dq_i | input | 8 | Data bus as read from memory |
| mem_dq_o | output | 8 | Data bus value to drive |
| mem_dq_oe | output | 1 | Data bus output enable |
| mem_rd_n | output | 1 | Memory read strobe |
| mem_wr_n | output | 1 | Memory write strobe |
| mem_rom_cs_n | output | 1 | ROM chip select |
| mem_ram_cs_n | output | 1 | RAM chip select |

## Verification
The assertions take for granted that the TAP pulses are single-cycle and mutually exclusive. They also assume that the command word and the device select are held steady across a whole operation, and that the host waits for an access to finish before sending the next pulse. The bench gives every pulse its own clock and keeps the command fixed through each shift-and-update sequence. After every capture or update it waits several clocks more than the longest access. It changes test mode only while the engine is idle.

// File: rtl/jte_pkg.sv
package jte_pkg;
  typedef enum logic [1:0] {
    CMD_ALOAD = 2'b00,
    CMD_AINC  = 2'b01,
    CMD_READ  = 2'b10,
    CMD_WRITE = 2'b11
  } jte_cmd_e;

  typedef enum logic [1:0] {
    ACC_IDLE = 2'b00,
    ACC_RD   = 2'b01,
    ACC_WR   = 2'b10
  } jte_acc_e;
endpackage

// File: rtl/jte_addr_path.sv
module jte_addr_path #(
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shift_en,
  input  logic          cap_en,
  input  logic          load_en,
  input  logic          inc_en,
  input  logic          tdi,
  output logic [AW-1:0] addr_q,
  output logic          chain_lsb
);
  logic [AW-1:0] chain_q;

  function automatic logic [AW-1:0] step_addr(input logic [AW-1:0] a);
    return a + AW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      addr_q  <= '0;
    end else begin
      if (cap_en)        chain_q <= addr_q;
      else if (shift_en) chain_q <= {tdi, chain_q[AW-1:1]};
      if (load_en)       addr_q  <= chain_q;
      else if (inc_en)   addr_q  <= step_addr(addr_q);
    end
  end

  assign chain_lsb = chain_q[0];
endmodule

// File: rtl/jte_data_path.sv
module jte_data_path #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shift_en,
  input  logic          load_en,
  input  logic          tdi,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] data_q,
  output logic          chain_lsb
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        data_q <= '0;
    else if (load_en)  data_q <= din;
    else if (shift_en) data_q <= {tdi, data_q[DW-1:1]};
  end

  assign chain_lsb = data_q[0];
endmodule

// File: rtl/jte_access_seq.sv
module jte_access_seq
  import jte_pkg::*;
#(
  parameter int RD_CYCLES = 3,
  parameter int WR_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_rd,
  input  logic start_wr,
  input  logic dev_sel,
  output logic busy,
  output logic rd_act,
  output logic wr_act,
  output logic rom_act,
  output logic ram_act,
  output logic rd_done
);
  localparam int MAXC = (RD_CYCLES > WR_CYCLES) ? RD_CYCLES : WR_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);

  jte_acc_e       state_q;
  logic [CW-1:0]  cnt_q;
  logic           dev_q;
  logic           last_cyc;

  assign last_cyc = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ACC_IDLE;
      cnt_q   <= '0;
      dev_q   <= 1'b0;
    end else begin
      case (state_q)
        ACC_IDLE: begin
          if (start_rd) begin
            state_q <= ACC_RD;
            cnt_q   <= CW'(RD_CYCLES - 1);
            dev_q   <= dev_sel;
          end else if (start_wr) begin
            state_q <= ACC_WR;
            cnt_q   <= CW'(WR_CYCLES - 1);
            dev_q   <= dev_sel;
          end
        end
        default: begin
          if (last_cyc) state_q <= ACC_IDLE;
          else          cnt_q   <= cnt_q - CW'(1);
        end
      endcase
    end
  end

  assign busy    = (state_q != ACC_IDLE);
  assign rd_act  = (state_q == ACC_RD);
  assign wr_act  = (state_q == ACC_WR);
  assign rom_act = busy & ~dev_q;
  assign ram_act = busy & dev_q;
  assign rd_done = rd_act & last_cyc;
endmodule

// File: rtl/jte_pin_mux.sv
module jte_pin_mux (
  input  logic test_mode,
  input  logic rd_act,
  input  logic wr_act,
  input  logic rom_act,
  input  logic ram_act,
  input  logic cpu_rd_n,
  input  logic cpu_wr_n,
  input  logic cpu_rom_cs_n,
  input  logic cpu_ram_cs_n,
  output logic cpu_rst_n,
  output logic mem_addr_oe,
  output logic mem_dq_oe,
  output logic mem_rd_n,
  output logic mem_wr_n,
  output logic mem_rom_cs_n,
  output logic mem_ram_cs_n
);
  always_comb begin
    if (test_mode) begin
      cpu_rst_n    = 1'b0;
      mem_addr_oe  = 1'b1;
      mem_dq_oe    = wr_act;
      mem_rd_n     = ~rd_act;
      mem_wr_n     = ~wr_act;
      mem_rom_cs_n = ~rom_act;
      mem_ram_cs_n = ~ram_act;
    end else begin
      cpu_rst_n    = 1'b1;
      mem_addr_oe  = 1'b0;
      mem_dq_oe    = 1'b0;
      mem_rd_n     = cpu_rd_n;
      mem_wr_n     = cpu_wr_n;
      mem_rom_cs_n = cpu_rom_cs_n;
      mem_ram_cs_n = cpu_ram_cs_n;
    end
  end
endmodule

// File: rtl/jte_mem_engine.sv
module jte_mem_engine
  import jte_pkg::*;
#(
  parameter int AW        = 20,
  parameter int DW        = 8,
  parameter int RD_CYCLES = 3,
  parameter int WR_CYCLES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          test_mode,
  input  logic          dr_sel,
  input  logic [1:0]    cmd,
  input  logic          cap_dr,
  input  logic          shift_dr,
  input  logic          upd_dr,
  input  logic          tdi,
  output logic          tdo,
  input  logic          dev_sel,
  input  logic          cpu_rd_n,
  input  logic          cpu_wr_n,
  input  logic          cpu_rom_cs_n,
  input  logic          cpu_ram_cs_n,
  output logic          cpu_rst_n,
  output logic [AW-1:0] mem_addr,
  output logic          mem_addr_oe,
  input  logic [DW-1:0] mem_dq_i,
  output logic [DW-1:0] mem_dq_o,
  output logic          mem_dq_oe,
  output logic          mem_rd_n,
  output logic          mem_wr_n,
  output logic          mem_rom_cs_n,
  output logic          mem_ram_cs_n
);
  jte_cmd_e cmd_e;
  assign cmd_e = jte_cmd_e'(cmd);

  // Named internal events
  logic acc_busy, rd_act, wr_act, rom_act, ram_act, rd_done;
  logic eng_en;
  logic op_acap, op_aload, op_ainc, op_rd_start, op_wr_start;
  logic shift_addr, shift_data;
  logic addr_lsb, data_lsb;

  assign eng_en      = test_mode & dr_sel & ~acc_busy;
  assign op_acap     = eng_en & cap_dr   & (cmd_e == CMD_ALOAD);
  assign op_aload    = eng_en & upd_dr   & (cmd_e == CMD_ALOAD);
  assign op_ainc     = eng_en & upd_dr   & (cmd_e == CMD_AINC);
  assign op_rd_start = eng_en & cap_dr   & (cmd_e == CMD_READ);
  assign op_wr_start = eng_en & upd_dr   & (cmd_e == CMD_WRITE);
  assign shift_addr  = eng_en & shift_dr & (cmd_e == CMD_ALOAD);
  assign shift_data  = eng_en & shift_dr & cmd[1];

  jte_addr_path #(.AW(AW)) u_addr (
    .clk(clk), .rst_n(rst_n),
    .shift_en(shift_addr), .cap_en(op_acap),
    .load_en(op_aload), .inc_en(op_ainc),
    .tdi(tdi), .addr_q(mem_addr), .chain_lsb(addr_lsb)
  );

  jte_data_path #(.DW(DW)) u_data (
    .clk(clk), .rst_n(rst_n),
    .shift_en(shift_data), .load_en(rd_done),
    .tdi(tdi), .din(mem_dq_i),
    .data_q(mem_dq_o), .chain_lsb(data_lsb)
  );

  jte_access_seq #(.RD_CYCLES(RD_CYCLES), .WR_CYCLES(WR_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .start_rd(op_rd_start), .start_wr(op_wr_start), .dev_sel(dev_sel),
    .busy(acc_busy), .rd_act(rd_act), .wr_act(wr_act),
    .rom_act(rom_act), .ram_act(ram_act), .rd_done(rd_done)
  );

  jte_pin_mux u_mux (
    .test_mode(test_mode),
    .rd_act(rd_act), .wr_act(wr_act), .rom_act(rom_act), .ram_act(ram_act),
    .cpu_rd_n(cpu_rd_n), .cpu_wr_n(cpu_wr_n),
    .cpu_rom_cs_n(cpu_rom_cs_n), .cpu_ram_cs_n(cpu_ram_cs_n),
    .cpu_rst_n(cpu_rst_n), .mem_addr_oe(mem_addr_oe), .mem_dq_oe(mem_dq_oe),
    .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
    .mem_rom_cs_n(mem_rom_cs_n), .mem_ram_cs_n(mem_ram_cs_n)
  );

  always_comb begin
    case (cmd_e)
      CMD_ALOAD: tdo = addr_lsb;
      CMD_AINC:  tdo = 1'b0;
      default:   tdo = data_lsb;
    endcase
  end
endmodule

// File: rtl/jte_mem_engine_chk.sv
module jte_mem_engine_chk #(
  parameter int AW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          test_mode,
  input logic          cpu_rd_n,
  input logic          cpu_wr_n,
  input logic          cpu_rst_n,
  input logic          mem_rd_n,
  input logic          mem_wr_n,
  input logic          mem_rom_cs_n,
  input logic          mem_ram_cs_n,
  input logic          mem_dq_oe,
  input logic          mem_addr_oe,
  input logic [AW-1:0] mem_addr,
  input logic          acc_busy,
  input logic          op_ainc
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode && !acc_busy) |-> (mem_rd_n && mem_wr_n && mem_rom_cs_n && mem_ram_cs_n && !mem_dq_oe)); // R1
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    op_ainc |=> (mem_addr == AW'($past(mem_addr) + AW'(1)))); // R3
  AST_ADDR_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_busy && $past(acc_busy)) |-> $stable(mem_addr)); // R4
  AST_DQ_WITH_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode && mem_dq_oe) |-> (!mem_wr_n && mem_rd_n)); // R5
  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    test_mode |-> ($countones({~mem_rom_cs_n, ~mem_ram_cs_n}) <= 1)); // R6
  AST_CPU_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    test_mode |-> (!cpu_rst_n && mem_addr_oe)); // R7
  AST_PASS_THRU: assert property (@(posedge clk) disable iff (!rst_n)
    !test_mode |-> (mem_rd_n == cpu_rd_n && mem_wr_n == cpu_wr_n && cpu_rst_n && !mem_dq_oe && !mem_addr_oe)); // R8
endmodule

bind jte_mem_engine jte_mem_engine_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .test_mode(test_mode),
  .cpu_rd_n(cpu_rd_n), .cpu_wr_n(cpu_wr_n), .cpu_rst_n(cpu_rst_n),
  .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
  .mem_rom_cs_n(mem_rom_cs_n), .mem_ram_cs_n(mem_ram_cs_n),
  .mem_dq_oe(mem_dq_oe), .mem_addr_oe(mem_addr_oe), .mem_addr(mem_addr),
  .acc_busy(acc_busy), .op_ainc(op_ainc)
);

// File: tb/jte_mem_engine_tb_top.sv
module jte_mem_engine_tb_top;
  localparam int CLK_P = 10;
  localparam int AW = 20;
  localparam int DW = 8;
  localparam int RDC = 3;
  localparam int WRC = 4;
  localparam int NV = 6;
  // {dev, addr, data}
  localparam logic [28:0] VEC [NV] = '{
    {1'b0, 20'h00000, 8'h3C},
    {1'b0, 20'h12345, 8'hA5},
    {1'b0, 20'hABCDE, 8'h81},
    {1'b0, 20'h7FF80, 8'hFF},
    {1'b1, 20'h000FF, 8'h5A},
    {1'b1, 20'h55501, 8'h00}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic test_mode = 1'b0, dr_sel = 1'b0;
  logic [1:0] cmd = 2'b00;
  logic cap_dr = 0, shift_dr = 0, upd_dr = 0, tdi = 0, dev_sel = 0;
  logic cpu_rd_n = 1, cpu_wr_n = 1, cpu_rom_cs_n = 1, cpu_ram_cs_n = 1;
  logic tdo, cpu_rst_n, mem_addr_oe, mem_dq_oe;
  logic mem_rd_n, mem_wr_n, mem_rom_cs_n, mem_ram_cs_n;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_dq_i, mem_dq_o;
  logic [7:0] rom_m [256];
  logic [7:0] ram_m [256];
  int n_chk = 0, n_bad = 0;
  int lo_cnt, oe_bad;
  logic [31:0] sh_out;

  always #(CLK_P/2) clk = ~clk;

  jte_mem_engine #(.AW(AW), .DW(DW), .RD_CYCLES(RDC), .WR_CYCLES(WRC)) dut_i (
    .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .dr_sel(dr_sel), .cmd(cmd),
    .cap_dr(cap_dr), .shift_dr(shift_dr), .upd_dr(upd_dr), .tdi(tdi), .tdo(tdo),
    .dev_sel(dev_sel), .cpu_rd_n(cpu_rd_n), .cpu_wr_n(cpu_wr_n),
    .cpu_rom_cs_n(cpu_rom_cs_n), .cpu_ram_cs_n(cpu_ram_cs_n), .cpu_rst_n(cpu_rst_n),
    .mem_addr(mem_addr), .mem_addr_oe(mem_addr_oe), .mem_dq_i(mem_dq_i),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_rd_n(mem_rd_n),
    .mem_wr_n(mem_wr_n), .mem_rom_cs_n(mem_rom_cs_n), .mem_ram_cs_n(mem_ram_cs_n)
  );

  // Behavioural memories, indexed by the low address byte
  always_comb begin
    if (!mem_rd_n && !mem_rom_cs_n)      mem_dq_i = rom_m[mem_addr[7:0]];
    else if (!mem_rd_n && !mem_ram_cs_n) mem_dq_i = ram_m[mem_addr[7:0]];
    else                                 mem_dq_i = 8'h00;
  end
  always @(posedge clk) begin
    if (!mem_wr_n && mem_dq_oe && !mem_rom_cs_n) rom_m[mem_addr[7:0]] <= mem_dq_o;
    if (!mem_wr_n && mem_dq_oe && !mem_ram_cs_n) ram_m[mem_addr[7:0]] <= mem_dq_o;
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic pulse_cap();
    @(negedge clk) cap_dr = 1;
    @(negedge clk) cap_dr = 0;
  endtask

  task automatic pulse_upd();
    @(negedge clk) upd_dr = 1;
    @(negedge clk) upd_dr = 0;
  endtask

  // Shift n bits LSB first; TDO sampled before each shift edge
  task automatic shift_bits(input logic [31:0] v, input int n);
    sh_out = '0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sh_out[i] = tdo;
      tdi = v[i];
      shift_dr = 1;
    end
    @(negedge clk) shift_dr = 0;
  endtask

  // Count strobe-low clocks after a pulse (sampled from the falling edge ending the pulse)
  task automatic count_lows(input bit wr);
    lo_cnt = 0; oe_bad = 0;
    for (int k = 0; k < RDC + WRC + 3; k++) begin
      if (k > 0) @(negedge clk);
      if (wr ? !mem_wr_n : !mem_rd_n) lo_cnt++;
      if (mem_dq_oe && mem_wr_n) oe_bad++;
    end
  endtask

  task automatic load_addr(input logic [AW-1:0] a);
    cmd = 2'b00;
    shift_bits(32'(a), AW);
    pulse_upd();
  endtask

  task automatic read_addr();
    cmd = 2'b00;
    pulse_cap();
    shift_bits(32'h0, AW);
  endtask

  task automatic step_addr();
    cmd = 2'b01;
    pulse_upd();
  endtask

  task automatic write_byte(input logic [7:0] d);
    cmd = 2'b11;
    shift_bits(32'(d), DW);
    @(negedge clk) upd_dr = 1;
    @(negedge clk) upd_dr = 0;
    count_lows(1'b1);
  endtask

  task automatic read_byte();
    cmd = 2'b10;
    @(negedge clk) cap_dr = 1;
    @(negedge clk) cap_dr = 0;
    count_lows(1'b0);
    shift_bits(32'h0, DW);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin rom_m[i] = 8'hEE; ram_m[i] = 8'hEE; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // Normal mode pass-through
    chk("R8 cpu_rst_n high", 32'(cpu_rst_n), 32'd1);
    chk("R8 addr not driven", 32'(mem_addr_oe), 32'd0);
    cpu_rd_n = 0; cpu_rom_cs_n = 0;
    @(negedge clk);
    chk("R8 rd pass", 32'({mem_rd_n, mem_wr_n, mem_rom_cs_n, mem_ram_cs_n}), 32'b0101);
    cpu_rd_n = 1; cpu_rom_cs_n = 1; cpu_wr_n = 0; cpu_ram_cs_n = 0;
    @(negedge clk);
    chk("R8 wr pass", 32'({mem_rd_n, mem_wr_n, mem_rom_cs_n, mem_ram_cs_n}), 32'b1010);
    chk("R8 dq not driven", 32'(mem_dq_oe), 32'd0);
    cpu_wr_n = 1; cpu_ram_cs_n = 1;
    // TAP pulses ignored in normal mode
    dr_sel = 1;
    step_addr();
    load_addr(20'h12345);
    // Test mode idle state
    test_mode = 1;
    @(negedge clk);
    chk("R7 cpu held", 32'(cpu_rst_n), 32'd0);
    chk("R7 addr oe", 32'(mem_addr_oe), 32'd1);
    chk("R1 idle strobes", 32'({mem_rd_n, mem_wr_n, mem_rom_cs_n, mem_ram_cs_n, mem_dq_oe}), 32'b11110);
    chk("R1/R8 addr after reset", 32'(mem_addr), 32'h0);
    read_addr();
    chk("R2 capture address", sh_out, 32'h0);

    // Vector table: write, step, read address, reload, read back
    for (int v = 0; v < NV; v++) begin
      logic [AW-1:0] a;
      logic [7:0] d;
      a = VEC[v][27:8];
      d = VEC[v][7:0];
      dev_sel = VEC[v][28];
      load_addr(a);
      chk("R2 address loaded", 32'(mem_addr), 32'(a));
      write_byte(d);
      chk("R5 write strobe length", 32'(lo_cnt), 32'(WRC));
      chk("R5 dq only with wr", 32'(oe_bad), 32'd0);
      chk("R6 write landed", 32'(VEC[v][28] ? ram_m[a[7:0]] : rom_m[a[7:0]]), 32'(d));
      step_addr();
      read_addr();
      chk("R3 step", sh_out, 32'(a + 20'd1));
      cmd = 2'b01;
      @(negedge clk);
      chk("R3 tdo zero", 32'(tdo), 32'd0);
      load_addr(a);
      read_byte();
      chk("R4 read strobe length", 32'(lo_cnt), 32'(RDC));
      chk("R4 read back", sh_out, 32'(d));
    end

    // Device select isolation: the ROM copy of a RAM address stays untouched
    chk("R6 rom untouched", 32'(rom_m[8'hFF]), 32'hEE);

    // Address wrap
    load_addr(20'hFFFFF);
    step_addr();
    chk("R3 wrap pin", 32'(mem_addr), 32'h0);
    read_addr();
    chk("R3 wrap chain", sh_out, 32'h0);

    // Chip select during a ROM read
    dev_sel = 0;
    load_addr(20'h00045);
    cmd = 2'b10;
    @(negedge clk) cap_dr = 1;
    @(negedge clk) cap_dr = 0;
    chk("R6 rom select only", 32'({mem_rom_cs_n, mem_ram_cs_n, mem_rd_n}), 32'b010);
    repeat (RDC + 2) @(negedge clk);
    chk("R1 idle after read", 32'({mem_rd_n, mem_rom_cs_n, mem_ram_cs_n}), 32'b111);
    shift_bits(32'h0, DW);
    chk("R4 rom byte", sh_out, 32'hA5);

    // Normal mode again: update ignored
    test_mode = 0;
    cmd = 2'b01;
    pulse_upd();
    test_mode = 1;
    read_addr();
    chk("R8 step ignored", sh_out, 32'h00045);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule